// File: doc/BRIEF.md
# Password Portion Unlock Checker

This block holds a secret key made of four 16-bit portions and decides whether a caller has proven knowledge of it. A command sequencer sits in front of it and hands over one portion per request: it can store a portion, read a portion back, or present a portion as part of an unlock attempt. Once all four presented portions have matched the stored ones, a separate end-of-sequence pulse turns the `unlocked` flag on. Logic outside this block uses that flag to decide whether writes to the persistent sector protection bits are allowed.

A one-way mode-lock bit hardens the key. Once it is set, readback returns all ones instead of the stored word, and any further attempt to store a portion is ignored. Unlock attempts are also paced: a presented portion that follows the previous one too quickly spoils the attempt. This keeps the comparison from being brute-forced at full clock rate.

Requests use a valid/ready channel. Readback data leaves on a second valid/ready channel that has a single output register. While that register holds a word the consumer has not taken, the request channel is held not-ready for every opcode, so no request is lost and no word is overwritten. The end-of-attempt pulse and the `unlocked` flag are plain pins.

Top module: `pwu_unlock_checker`

## Requirements
- R1: After reset `unlocked` is 0 and `rd_valid` is 0. Every portion reads back as 16'hFFFF, which is the default key.
- R2: `req_op` encodes 2'b00 = store portion, 2'b01 = read portion, 2'b10 = present portion for unlock, and 2'b11 = set mode lock. `req_idx` picks portion 0..3. A store changes only the indexed portion. A read that is accepted on a clock edge puts that portion on `rd_data`, with `rd_valid` high, right after that edge.
- R3: Once the mode lock is set, every read returns 16'hFFFF.
- R4: Once the mode lock is set, store requests leave the key unchanged. The mode lock stays set until reset.
- R5: A pulse on `attempt_done` sets `unlocked` right after that edge when all four portions were presented and matched since the last pulse.
- R6: A presented portion that does not match clears all match progress. Portions presented after that count afresh.
- R7: If any portion was not presented with a match, `attempt_done` clears `unlocked`.
- R8: Within an attempt, a presented portion accepted fewer than GAP_CYCLES clock edges after the previous one clears all match progress. A spacing of exactly GAP_CYCLES edges is allowed. The first portion after a pulse has no spacing limit.
- R9: `unlocked` changes only on an `attempt_done` pulse. A failing attempt clears it.
- R10: While `rd_valid` is high and `rd_ready` is low, `req_ready` is 0, and `rd_valid` and `rd_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_op | input | 2 | Request opcode (see R2) |
| req_idx | input | 2 | Portion index |
| req_data | input | 16 | Portion value for store or unlock |
| attempt_done | input | 1 | One-cycle pulse ending an unlock attempt |
| rd_valid | output | 1 | Readback word present |
| rd_ready | input | 1 | Consumer takes the readback word |
| rd_data | output | 16 | Readback word |
| unlocked | output | 1 | All four portions proven |

## Verification
Readback is due on the edge that accepts the read, and `unlocked` is due on the edge that samples `attempt_done`. Both are registered exactly once. The bench drives inputs on the falling edge and samples 1 ns after the rising edge that should produce the result. Pacing is measured in accepting edges, so the bench waits GAP_CYCLES-1 or GAP_CYCLES-2 extra rising edges after an accepting edge before it offers the next portion. This lands the next accept on exactly the allowed spacing or one edge short of it. Stall behaviour is checked by holding `rd_ready` low across several edges and observing `req_ready` and the held word.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  typedef enum logic [1:0] {
    PWU_STORE   = 2'b00,
    PWU_READ    = 2'b01,
    PWU_PRESENT = 2'b10,
    PWU_LOCKMD  = 2'b11
  } pwu_op_e;
endpackage

// File: rtl/pwu_key_store.sv
module pwu_key_store #(
  parameter int PORTION_W = 16,
  parameter int PORTIONS  = 4,
  parameter int IDX_W     = 2,
  parameter logic [PORTION_W*PORTIONS-1:0] RESET_KEY = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 store_en,
  input  logic                 lock_en,
  input  logic                 read_en,
  input  logic                 rd_ready,
  input  logic [IDX_W-1:0]     idx,
  input  logic [PORTION_W-1:0] wdata,
  output logic [PORTION_W-1:0] cmp_word,
  output logic                 rd_valid,
  output logic [PORTION_W-1:0] rd_data
);
  localparam int KEY_W = PORTION_W * PORTIONS;

  logic [KEY_W-1:0] key_flat;
  logic             mode_lock_q;

  // one register per portion, each with its own write decode
  for (genvar g = 0; g < PORTIONS; g++) begin : g_portion
    logic [PORTION_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= RESET_KEY[g*PORTION_W +: PORTION_W];
      end else if (store_en && !mode_lock_q && idx == IDX_W'(g)) begin
        word_q <= wdata;
      end
    end
    assign key_flat[g*PORTION_W +: PORTION_W] = word_q;
  end

  assign cmp_word = key_flat[idx*PORTION_W +: PORTION_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_lock_q <= 1'b0;
    end else if (lock_en) begin
      mode_lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (read_en) begin
      rd_valid <= 1'b1;
      rd_data  <= mode_lock_q ? {PORTION_W{1'b1}} : cmp_word;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    read_en |=> rd_valid); // R2
  AST_LOCKED_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && mode_lock_q) |=> rd_data == {PORTION_W{1'b1}}); // R3
  AST_MODE_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_lock_q |=> mode_lock_q); // R4
  AST_LOCKED_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lock_q && store_en) |=> $stable(key_flat)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10
endmodule

// File: rtl/pwu_gap_timer.sv
module pwu_gap_timer #(
  parameter int GAP_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic portion_acc,
  input  logic attempt_end,
  output logic too_soon
);
  localparam int CNT_W = $clog2(GAP_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  // cnt_q equals the number of edges since the last accepted portion (saturating)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (attempt_end) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (portion_acc) begin
      armed_q <= 1'b1;
      cnt_q   <= CNT_W'(1);
    end else if (cnt_q < CNT_W'(GAP_CYCLES)) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign too_soon = armed_q && (cnt_q < CNT_W'(GAP_CYCLES));

  AST_GAP_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (portion_acc && !attempt_end) |=> (GAP_CYCLES <= 1) || too_soon); // R8
  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_end |=> !too_soon); // R8
endmodule

// File: rtl/pwu_match_track.sv
module pwu_match_track #(
  parameter int PORTIONS = 4,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             portion_acc,
  input  logic [IDX_W-1:0] idx,
  input  logic             hit,
  input  logic             too_soon,
  input  logic             attempt_end,
  output logic             unlocked
);
  logic [PORTIONS-1:0] seen_q;
  logic [PORTIONS-1:0] idx_onehot;
  logic                good;

  for (genvar g = 0; g < PORTIONS; g++) begin : g_dec
    assign idx_onehot[g] = (idx == IDX_W'(g));
  end

  assign good = hit && !too_soon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q   <= '0;
      unlocked <= 1'b0;
    end else if (attempt_end) begin
      unlocked <= &seen_q;
      seen_q   <= '0;
    end else if (portion_acc) begin
      seen_q   <= good ? (seen_q | idx_onehot) : '0;
    end
  end

  AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (portion_acc && !attempt_end && !hit) |=> seen_q == '0); // R6
  AST_EARLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (portion_acc && !attempt_end && too_soon) |=> seen_q == '0); // R8
  AST_PARTIAL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_end && !(&seen_q)) |=> !unlocked); // R7
  AST_UNLOCK_ONLY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    !attempt_end |=> $stable(unlocked)); // R9
endmodule

// File: rtl/pwu_unlock_checker.sv
module pwu_unlock_checker #(
  parameter int PORTION_W  = 16,
  parameter int PORTIONS   = 4,
  parameter int GAP_CYCLES = 400,
  parameter logic [PORTION_W*PORTIONS-1:0] RESET_KEY = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_op,
  input  logic [$clog2(PORTIONS)-1:0]  req_idx,
  input  logic [PORTION_W-1:0]         req_data,
  input  logic                         attempt_done,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [PORTION_W-1:0]         rd_data,
  output logic                         unlocked
);
  import pwu_pkg::*;

  localparam int IDX_W = $clog2(PORTIONS);

  pwu_op_e          op;
  logic             acc;
  logic             store_en, read_en, lock_en, present_en;
  logic [PORTION_W-1:0] cmp_word;
  logic             too_soon;
  logic             hit;

  assign op        = pwu_op_e'(req_op);
  assign req_ready = !rd_valid || rd_ready;
  assign acc       = req_valid && req_ready;

  assign store_en   = acc && (op == PWU_STORE);
  assign read_en    = acc && (op == PWU_READ);
  assign present_en = acc && (op == PWU_PRESENT);
  assign lock_en    = acc && (op == PWU_LOCKMD);
  assign hit        = (cmp_word == req_data);

  pwu_key_store #(
    .PORTION_W(PORTION_W), .PORTIONS(PORTIONS), .IDX_W(IDX_W), .RESET_KEY(RESET_KEY)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .store_en(store_en), .lock_en(lock_en), .read_en(read_en),
    .rd_ready(rd_ready), .idx(req_idx), .wdata(req_data),
    .cmp_word(cmp_word), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  pwu_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .portion_acc(present_en), .attempt_end(attempt_done),
    .too_soon(too_soon)
  );

  pwu_match_track #(.PORTIONS(PORTIONS), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .portion_acc(present_en), .idx(req_idx), .hit(hit),
    .too_soon(too_soon), .attempt_end(attempt_done),
    .unlocked(unlocked)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (!unlocked && !rd_valid)); // R1
  AST_NO_STALL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && req_valid) |=> $stable(rd_data)); // R10
endmodule

// File: tb/pwu_unlock_checker_tb.sv
`timescale 1ns/1ps
module pwu_unlock_checker_tb;
  localparam int GAP = 400;
  localparam logic [63:0] KEY = {16'hC0DE, 16'h1234, 16'hBEEF, 16'h5A5A};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [1:0]  req_idx = 2'b00;
  logic [15:0] req_data = 16'h0000;
  logic        attempt_done = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        unlocked;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwu_unlock_checker #(.GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_idx(req_idx), .req_data(req_data), .attempt_done(attempt_done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .unlocked(unlocked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns 1 ns after the accepting edge
  task automatic issue(input logic [1:0] op, input logic [1:0] idx, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_idx = idx; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic end_attempt();
    @(negedge clk);
    attempt_done = 1'b1;
    @(posedge clk);
    #1 attempt_done = 1'b0;
  endtask

  task automatic read_expect(input logic [1:0] idx, input logic [15:0] exp, input string req);
    issue(2'b01, idx, 16'h0000);
    chk({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    chk({req, " rd_data"}, {16'd0, rd_data}, {16'd0, exp});
  endtask

  // presents the four words; gap1 is the spacing used between portion 0 and 1
  task automatic present_all(input logic [63:0] k, input int gap1, input int count);
    for (int i = 0; i < count; i++) begin
      if (i > 0) repeat (((i == 1) ? gap1 : GAP) - 1) @(posedge clk);
      issue(2'b10, 2'(i), k[i*16 +: 16]);
    end
  endtask

  task automatic t_reset();
    chk("R1 unlocked", {31'd0, unlocked}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    for (int i = 0; i < 4; i++) read_expect(2'(i), 16'hFFFF, "R1 default key");
  endtask

  task automatic t_store_read();
    for (int i = 0; i < 4; i++) issue(2'b00, 2'(i), KEY[i*16 +: 16]);
    for (int i = 3; i >= 0; i--) read_expect(2'(i), KEY[i*16 +: 16], "R2 readback");
    issue(2'b00, 2'd2, 16'h0F0F);
    read_expect(2'd1, KEY[31:16], "R2 neighbour untouched");
    read_expect(2'd2, 16'h0F0F, "R2 single portion");
    issue(2'b00, 2'd2, KEY[47:32]);
  endtask

  task automatic t_unlock_good();
    present_all(KEY, GAP, 4);
    end_attempt();
    chk("R5 unlock all match", {31'd0, unlocked}, 32'd1);
  endtask

  task automatic t_wrong_middle();
    logic [63:0] bad = KEY;
    bad[31:16] = 16'h1235;
    present_all(bad, GAP, 4);
    end_attempt();
    chk("R9 failed attempt clears", {31'd0, unlocked}, 32'd0);
  endtask

  task automatic t_reentry();
    issue(2'b10, 2'd0, 16'h0000);
    repeat (GAP - 1) @(posedge clk);
    present_all(KEY, GAP, 4);
    end_attempt();
    chk("R6 fresh count after mismatch", {31'd0, unlocked}, 32'd1);
  endtask

  task automatic t_missing();
    present_all(KEY, GAP, 3);
    repeat (20) @(posedge clk);
    chk("R9 no change without pulse", {31'd0, unlocked}, 32'd1);
    end_attempt();
    chk("R7 missing portion", {31'd0, unlocked}, 32'd0);
  endtask

  task automatic t_gap();
    present_all(KEY, GAP - 1, 4);
    end_attempt();
    chk("R8 early portion", {31'd0, unlocked}, 32'd0);
    present_all(KEY, GAP, 4);
    end_attempt();
    chk("R8 exact spacing", {31'd0, unlocked}, 32'd1);
  endtask

  task automatic t_backpressure();
    rd_ready = 1'b0;
    read_expect(2'd1, KEY[31:16], "R10 stalled read");
    @(negedge clk);
    chk("R10 req_ready low", {31'd0, req_ready}, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 rd_valid held", {31'd0, rd_valid}, 32'd1);
    chk("R10 rd_data held", {16'd0, rd_data}, {16'd0, KEY[31:16]});
    @(negedge clk);
    rd_ready = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 drained", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_mode_lock();
    logic [63:0] alt = KEY;
    alt[15:0] = 16'h7777;
    issue(2'b11, 2'd0, 16'h0000);
    read_expect(2'd0, 16'hFFFF, "R3 masked read");
    read_expect(2'd3, 16'hFFFF, "R3 masked read");
    issue(2'b00, 2'd0, 16'h7777);
    present_all(alt, GAP, 4);
    end_attempt();
    chk("R4 refused store not usable", {31'd0, unlocked}, 32'd0);
    present_all(KEY, GAP, 4);
    end_attempt();
    chk("R4 old key still valid", {31'd0, unlocked}, 32'd1);
    read_expect(2'd1, 16'hFFFF, "R4 lock sticky");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_store_read();
    t_unlock_good();
    t_wrong_middle();
    t_reentry();
    t_missing();
    t_gap();
    t_backpressure();
    t_mode_lock();
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule